// File: doc/BRIEF.md
# Execute-Stage Operand Forwarding Unit

This block sits beside the execute stage of a five-stage in-order pipeline. It decides where each of the two ALU operands should come from. It looks at the two source register numbers of the instruction now in execute. It compares them with the destination numbers and write enables of the two older instructions still in flight: one in the memory stage, one in write-back. The unit drives a 2-bit select for each operand and applies that select to produce the operand itself. Results that have not yet reached the register file therefore reach the ALU without waiting.

The same block also provides the write-through path for the two register-file read ports in decode. When write-back writes a register in the same cycle that decode reads it, decode receives the value being written rather than the old array contents. The logic is purely combinational. Hazard stalls, the ALU and the register array itself are outside this block.

Top module: `fwd_unit`

## Requirements
- R1: `sel_a` is 2'b10 (memory-stage result) whenever `mem_we` is 1, `mem_rd` is nonzero and `mem_rd` equals `ex_rs`.
- R2: `sel_a` is 2'b01 (write-back result) when `wb_we` is 1, `wb_rd` is nonzero, `wb_rd` equals `ex_rs`, and the R1 condition does not hold.
- R3: When both the memory stage and the write-back stage match the same source, the memory-stage result (2'b10) is selected, because it is the younger value.
- R4: A producer whose write enable is 0, or whose destination is register 0, never causes forwarding. With no match, the select is 2'b00 (register value from decode).
- R5: `sel_b` follows the rules of R1 to R4 using `ex_rt`, independently of `sel_a`.
- R6: `opnd_a` and `opnd_b` equal the decode value (`ex_a_val` or `ex_b_val`) for select 2'b00, `mem_res` for 2'b10, and `wb_res` for 2'b01. A select of 2'b11 never occurs.
- R7: `dec_d1` equals `wb_res` when `wb_we` is 1, `wb_rd` is nonzero and `wb_rd` equals `dec_ra1`. Otherwise it equals `rf_q1`. `dec_d2` follows the same rule with `dec_ra2` and `rf_q2`.
- R8: A read of register 0 in decode always returns the array value, even while write-back targets register 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| ex_rs | input | AW | first source register of the execute-stage instruction |
| ex_rt | input | AW | second source register of the execute-stage instruction |
| ex_a_val | input | DW | first operand as read in decode |
| ex_b_val | input | DW | second operand as read in decode |
| mem_we | input | 1 | memory-stage instruction writes a register |
| mem_rd | input | AW | memory-stage destination register |
| mem_res | input | DW | memory-stage result |
| wb_we | input | 1 | write-back instruction writes a register |
| wb_rd | input | AW | write-back destination register |
| wb_res | input | DW | write-back data |
| dec_ra1 | input | AW | decode read address, port 1 |
| dec_ra2 | input | AW | decode read address, port 2 |
| rf_q1 | input | DW | register array data, port 1 |
| rf_q2 | input | DW | register array data, port 2 |
| sel_a | output | 2 | source select for operand A |
| sel_b | output | 2 | source select for operand B |
| opnd_a | output | DW | ALU operand A |
| opnd_b | output | DW | ALU operand B |
| dec_d1 | output | DW | bypassed decode read data, port 1 |
| dec_d2 | output | DW | bypassed decode read data, port 2 |

## Verification
The block holds no state, so a faulty comparison shows at the ports in the same cycle as the inputs that expose it. It appears as a wrong select code, and the operand carries a value from the wrong stage. The vectors give each producer stage and each operand its own data value. A priority inversion, a missing register-0 guard or crossed A/B wiring therefore gives a distinct, visible operand value. The decode write-through is checked separately on both ports, including the register-0 case.

// File: rtl/fwd_unit.sv
module fwd_unit #(
  parameter int AW = 5,
  parameter int DW = 32
) (
  input  logic [AW-1:0] ex_rs,
  input  logic [AW-1:0] ex_rt,
  input  logic [DW-1:0] ex_a_val,
  input  logic [DW-1:0] ex_b_val,
  input  logic          mem_we,
  input  logic [AW-1:0] mem_rd,
  input  logic [DW-1:0] mem_res,
  input  logic          wb_we,
  input  logic [AW-1:0] wb_rd,
  input  logic [DW-1:0] wb_res,
  input  logic [AW-1:0] dec_ra1,
  input  logic [AW-1:0] dec_ra2,
  input  logic [DW-1:0] rf_q1,
  input  logic [DW-1:0] rf_q2,
  output logic [1:0]    sel_a,
  output logic [1:0]    sel_b,
  output logic [DW-1:0] opnd_a,
  output logic [DW-1:0] opnd_b,
  output logic [DW-1:0] dec_d1,
  output logic [DW-1:0] dec_d2
);
  localparam logic [1:0] SRC_RF  = 2'b00;
  localparam logic [1:0] SRC_MEM = 2'b10;
  localparam logic [1:0] SRC_WB  = 2'b01;

  logic mem_live, wb_live;
  assign mem_live = mem_we && (mem_rd != '0);
  assign wb_live  = wb_we  && (wb_rd  != '0);

  function automatic logic [1:0] pick(input logic [AW-1:0] src);
    if (mem_live && mem_rd == src)     pick = SRC_MEM;
    else if (wb_live && wb_rd == src)  pick = SRC_WB;
    else                               pick = SRC_RF;
  endfunction

  function automatic logic [DW-1:0] route(input logic [1:0] s, input logic [DW-1:0] rf);
    case (s)
      SRC_MEM: route = mem_res;
      SRC_WB:  route = wb_res;
      default: route = rf;
    endcase
  endfunction

  assign sel_a  = pick(ex_rs);
  assign sel_b  = pick(ex_rt);
  assign opnd_a = route(sel_a, ex_a_val);
  assign opnd_b = route(sel_b, ex_b_val);

  assign dec_d1 = (wb_live && wb_rd == dec_ra1) ? wb_res : rf_q1;
  assign dec_d2 = (wb_live && wb_rd == dec_ra2) ? wb_res : rf_q2;

  always_comb begin
    p_mem_sel_valid_r1: assert (sel_a != SRC_MEM || (mem_we && mem_rd == ex_rs && ex_rs != '0));
    p_wb_sel_valid_r2: assert (sel_a != SRC_WB || (wb_we && wb_rd == ex_rs && ex_rs != '0));
    p_younger_wins_r3: assert (!(mem_we && mem_rd == ex_rs && ex_rs != '0) || sel_a == SRC_MEM);
    p_zero_reg_r4: assert (ex_rs != '0 || sel_a == SRC_RF);
    p_b_zero_reg_r5: assert (ex_rt != '0 || sel_b == SRC_RF);
    p_no_code3_r6: assert (sel_a != 2'b11 && sel_b != 2'b11);
    p_opnd_mem_r6: assert (sel_b != SRC_MEM || opnd_b == mem_res);
    p_wt_port1_r7: assert (!(wb_we && wb_rd == dec_ra1 && dec_ra1 != '0) || dec_d1 == wb_res);
    p_rd_zero_r8: assert (dec_ra2 != '0 || dec_d2 == rf_q2);
  end
endmodule

// File: tb/sim_fwd_unit.sv
module sim_fwd_unit;
  localparam int AW = 5;
  localparam int DW = 32;
  localparam int NV = 12;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic [AW-1:0] ex_rs, ex_rt, mem_rd, wb_rd, dec_ra1, dec_ra2;
  logic [DW-1:0] ex_a_val, ex_b_val, mem_res, wb_res, rf_q1, rf_q2;
  logic          mem_we, wb_we;
  logic [1:0]    sel_a, sel_b;
  logic [DW-1:0] opnd_a, opnd_b, dec_d1, dec_d2;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  fwd_unit #(.AW(AW), .DW(DW)) u0 (
    .ex_rs(ex_rs), .ex_rt(ex_rt), .ex_a_val(ex_a_val), .ex_b_val(ex_b_val),
    .mem_we(mem_we), .mem_rd(mem_rd), .mem_res(mem_res),
    .wb_we(wb_we), .wb_rd(wb_rd), .wb_res(wb_res),
    .dec_ra1(dec_ra1), .dec_ra2(dec_ra2), .rf_q1(rf_q1), .rf_q2(rf_q2),
    .sel_a(sel_a), .sel_b(sel_b), .opnd_a(opnd_a), .opnd_b(opnd_b),
    .dec_d1(dec_d1), .dec_d2(dec_d2)
  );

  // {rs, rt, mem_we, mem_rd, wb_we, wb_rd, exp_sel_a, exp_sel_b}
  localparam logic [25:0] VEC [NV] = '{
    {5'd3,  5'd4,  1'b1, 5'd3,  1'b0, 5'd0,  2'b10, 2'b00}, // R1
    {5'd3,  5'd4,  1'b1, 5'd4,  1'b0, 5'd0,  2'b00, 2'b10}, // R5
    {5'd3,  5'd4,  1'b0, 5'd0,  1'b1, 5'd3,  2'b01, 2'b00}, // R2
    {5'd3,  5'd4,  1'b0, 5'd0,  1'b1, 5'd4,  2'b00, 2'b01}, // R5
    {5'd3,  5'd4,  1'b1, 5'd3,  1'b1, 5'd3,  2'b10, 2'b00}, // R3
    {5'd7,  5'd7,  1'b1, 5'd7,  1'b1, 5'd7,  2'b10, 2'b10}, // R3
    {5'd0,  5'd0,  1'b1, 5'd0,  1'b1, 5'd0,  2'b00, 2'b00}, // R4 register 0
    {5'd3,  5'd4,  1'b0, 5'd3,  1'b0, 5'd4,  2'b00, 2'b00}, // R4 enables low
    {5'd3,  5'd4,  1'b1, 5'd4,  1'b1, 5'd3,  2'b01, 2'b10}, // R2 R5
    {5'd5,  5'd5,  1'b0, 5'd5,  1'b1, 5'd5,  2'b01, 2'b01}, // R2
    {5'd31, 5'd1,  1'b1, 5'd31, 1'b1, 5'd1,  2'b10, 2'b01}, // R1 R5
    {5'd3,  5'd3,  1'b1, 5'd0,  1'b1, 5'd3,  2'b01, 2'b01}  // R4 then R2
  };

  task automatic check(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [DW-1:0] want(input logic [1:0] s, input logic [DW-1:0] rf);
    return (s == 2'b10) ? mem_res : (s == 2'b01) ? wb_res : rf;
  endfunction

  task automatic idle();
    ex_rs = '0; ex_rt = '0; mem_we = 0; mem_rd = '0; wb_we = 0; wb_rd = '0;
    dec_ra1 = '0; dec_ra2 = '0;
  endtask

  initial begin
    ex_a_val = 32'hAAAA_0001; ex_b_val = 32'hBBBB_0002;
    mem_res  = 32'hCCCC_0003; wb_res   = 32'hDDDD_0004;
    rf_q1    = 32'h1111_0005; rf_q2    = 32'h2222_0006;
    idle();
    @(negedge clk);
    check("R4 idle sel_a", {30'd0, sel_a}, 32'd0);
    check("R4 idle sel_b", {30'd0, sel_b}, 32'd0);
    check("R6 idle opnd_a", opnd_a, ex_a_val);

    for (int i = 0; i < NV; i++) begin
      @(posedge clk);
      {ex_rs, ex_rt, mem_we, mem_rd, wb_we, wb_rd} = VEC[i][25:4];
      @(negedge clk);
      check($sformatf("R1/R2/R3/R4 vec%0d sel_a", i), {30'd0, sel_a}, {30'd0, VEC[i][3:2]});
      check($sformatf("R5 vec%0d sel_b", i), {30'd0, sel_b}, {30'd0, VEC[i][1:0]});
      check($sformatf("R6 vec%0d opnd_a", i), opnd_a, want(VEC[i][3:2], ex_a_val));
      check($sformatf("R6 vec%0d opnd_b", i), opnd_b, want(VEC[i][1:0], ex_b_val));
    end

    @(posedge clk); idle(); wb_we = 1; wb_rd = 5'd9; dec_ra1 = 5'd9; dec_ra2 = 5'd8;
    @(negedge clk);
    check("R7 port1 write-through", dec_d1, wb_res);
    check("R7 port2 no match", dec_d2, rf_q2);

    @(posedge clk); dec_ra1 = 5'd8; dec_ra2 = 5'd9;
    @(negedge clk);
    check("R7 port1 no match", dec_d1, rf_q1);
    check("R7 port2 write-through", dec_d2, wb_res);

    @(posedge clk); wb_we = 0;
    @(negedge clk);
    check("R7 enable low port2", dec_d2, rf_q2);

    @(posedge clk); wb_we = 1; wb_rd = 5'd0; dec_ra1 = 5'd0; dec_ra2 = 5'd0;
    @(negedge clk);
    check("R8 zero read port1", dec_d1, rf_q1);
    check("R8 zero read port2", dec_d2, rf_q2);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule